// File: doc/BRIEF.md
# Scratchpad Write and Readback Controller with Authorization Flag

This block sits behind the bit layer of a single-line serial memory slave and owns the small staging buffer that every memory write passes through. Once the bit layer has seen a bus reset and the device has been selected, it hands over received bits one at a time. It also requests outgoing bits one slot at a time. The controller decodes a command byte and runs one of three sequences. A write loads a target address and a block of data bytes into the buffer. A readback replays the address, a status byte, the buffer and a checksum. A copy request raises an authorization flag when an external check says the copy may go ahead.

The target address is stored aligned to the buffer size: its low bits are cleared whatever the master sends. The status byte reports whether the last write ended part way through a byte and whether the buffer contents were accepted for copying. Both write and readback offer the master an inverted CRC-16 so that it can confirm the transfer. A bus reset in mid-sequence abandons the sequence and keeps everything already stored.

Top module: `spad_wr_ctrl`

## Requirements
- R1: After each bus reset, the first 8 received bits, taken least significant bit first, form the command. 0x0F starts a write, 0xAA starts a readback and 0x55 is a copy request. Any other value makes the block ignore received bits until the next bus reset.
- R2: A write takes a low address byte and then a high address byte. The low byte is stored with bits [2:0] cleared. The high byte is stored as sent.
- R3: Write data bytes go to buffer positions 0 to 7 in arrival order. A byte left incomplete is not stored. Received bits after the 64th data bit are ignored.
- R4: The status byte has the authorization flag in bit 7 and the partial flag in bit 5. Bits 6 and 4 to 0 always read 1.
- R5: Each received data bit sets the partial flag to 1 if the data bit count is then not a multiple of 8, and clears it otherwise. Power-on reset sets the partial flag.
- R6: Decoding a write command clears the authorization flag. A copy request loads the flag with the value (authorization input AND NOT partial flag).
- R7: After the 64th data bit of a write, the next 16 read slots return the complement of a CRC-16 (polynomial x^16+x^15+x^2+1, start value 0, input bits taken least significant bit first). The CRC covers the command byte, the address bytes as sent and the data. Its low byte is sent first.
- R8: A readback returns, least significant bit first: the stored low address byte, the high address byte, the status byte, the 8 buffer bytes, and then the complemented CRC-16 (as in R7) over the command byte and those 11 bytes, low byte first.
- R9: A bus reset ends any sequence at once. Stored address, data and flags keep their values, and the next received bits form a new command.
- R10: After power-on reset, the address bytes and buffer are 0, the partial flag is 1 and the authorization flag is 0.
- R11: Read slots outside the checksum and readback phases return 1 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_reset | input | 1 | Bus reset seen by the bit layer; aborts the current sequence |
| rx_valid | input | 1 | One received bit is present on rx_bit this cycle |
| rx_bit | input | 1 | Received bit value |
| rd_req | input | 1 | The master consumes the current tx_bit in this cycle |
| auth_ok | input | 1 | Result of the external authorization check, sampled on a copy request |
| tx_bit | output | 1 | Bit offered for the next read slot |

## Verification
The bench builds the block with its defaults: an 8-byte buffer, three clear address bits and the command codes listed above. These values make every buffer position, the aligned-address rule and both checksum frames reachable in a few hundred cycles per sequence. The random writes are cut off at arbitrary bit counts, so the partial flag is driven both ways, through byte boundaries and the full 64-bit end, and copy requests then meet that flag with the authorization input both high and low.

// File: rtl/spad_pkg.sv
package spad_pkg;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DATA,
      PH_WCRC,
      PH_READ,
      PH_IDLE
   } spad_phase_e;

   // One LSB-first step of a reflected CRC register.
   function automatic logic [15:0] crc_step(input logic [15:0] c,
                                            input logic        b,
                                            input logic [15:0] poly);
      logic [15:0] n;
      n = c >> 1;
      if (c[0] ^ b) n = n ^ poly;
      return n;
   endfunction

endpackage

// File: rtl/spad_crc16.sv
module spad_crc16 #(
   parameter logic [15:0] POLY_REFL  = 16'hA001,
   parameter bit          INVERT_OUT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic        din,
   output logic [15:0] crc_out
);
   import spad_pkg::*;

   logic [15:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '0;
      else if (clr) crc_q <= '0;
      else if (en)  crc_q <= crc_step(crc_q, din, POLY_REFL);
   end

   generate
      if (INVERT_OUT) begin : g_inv
         assign crc_out = ~crc_q;
      end else begin : g_true
         assign crc_out = crc_q;
      end
   endgenerate

endmodule

// File: rtl/spad_flags.sv
module spad_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_start,
   input  logic data_evt,
   input  logic data_aligned,
   input  logic copy_evt,
   input  logic auth_ok,
   output logic pf,
   output logic aa
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf <= 1'b1;
         aa <= 1'b0;
      end else begin
         if (data_evt) pf <= ~data_aligned;
         if (wr_start)      aa <= 1'b0;
         else if (copy_evt) aa <= auth_ok & ~pf;
      end
   end

   assert_pf_fall_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pf) |-> $past(data_evt));

   assert_aa_rise_needs_auth_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aa) |-> $past(copy_evt && auth_ok && !pf));

   assert_aa_clear_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !aa);

endmodule

// File: rtl/spad_store.sv
module spad_store #(
   parameter int BYTES = 8,
   localparam int OFS_W = $clog2(BYTES),
   localparam int FLAT_W = BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ta_lo_we,
   input  logic              ta_hi_we,
   input  logic [7:0]        ta_din,
   input  logic              d_we,
   input  logic [OFS_W-1:0]  d_idx,
   input  logic [7:0]        d_din,
   output logic [7:0]        ta_lo,
   output logic [7:0]        ta_hi,
   output logic [FLAT_W-1:0] data_flat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ta_lo <= '0;
         ta_hi <= '0;
      end else begin
         if (ta_lo_we) ta_lo <= ta_din;
         if (ta_hi_we) ta_hi <= ta_din;
      end
   end

   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_byte
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             q <= '0;
            else if (d_we && d_idx == OFS_W'(g))    q <= d_din;
         end
         assign data_flat[g*8 +: 8] = q;
      end
   endgenerate

   assert_ta_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ta_lo[OFS_W-1:0] == '0);

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !d_we |=> $stable(data_flat));

   assert_ta_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ta_lo_we || ta_hi_we) |=> ($stable(ta_lo) && $stable(ta_hi)));

endmodule

// File: rtl/spad_wr_ctrl.sv
module spad_wr_ctrl #(
   parameter int          BYTES    = 8,
   parameter logic [7:0]  CMD_WR   = 8'h0F,
   parameter logic [7:0]  CMD_RD   = 8'hAA,
   parameter logic [7:0]  CMD_CP   = 8'h55,
   parameter logic [15:0] CRC_POLY = 16'hA001
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_reset,
   input  logic rx_valid,
   input  logic rx_bit,
   input  logic rd_req,
   input  logic auth_ok,
   output logic tx_bit
);
   import spad_pkg::*;

   localparam int OFS_W     = $clog2(BYTES);
   localparam int DATA_BITS = BYTES * 8;
   localparam int PAY_BITS  = (BYTES + 3) * 8;
   localparam int RD_BITS   = (BYTES + 5) * 8;
   localparam int CNT_W     = $clog2(RD_BITS + 1);

   generate
      if (!(BYTES == 2 || BYTES == 4 || BYTES == 8)) begin : g_bad_bytes
         $error("spad_wr_ctrl: BYTES must be 2, 4 or 8");
      end
      if (CMD_WR == CMD_RD || CMD_WR == CMD_CP || CMD_RD == CMD_CP) begin : g_bad_cmd
         $error("spad_wr_ctrl: command codes must differ");
      end
   endgenerate

   spad_phase_e      phase;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       sh;

   logic       rx_take, rd_take, byte_done;
   logic [7:0] full_byte;
   logic       ta_lo_we, ta_hi_we, d_we;
   logic [7:0] ta_din;
   logic       wr_start, copy_evt, data_evt;
   logic       crc_en, crc_din;
   logic [15:0] crc_inv;
   logic       pf, aa;
   logic [7:0] ta_lo, ta_hi, es, rd_byte;
   logic [DATA_BITS-1:0] data_flat;
   int unsigned rd_bi;

   assign full_byte = {rx_bit, sh[7:1]};
   assign byte_done = (cnt[2:0] == 3'd7);
   assign rx_take   = rx_valid && !bus_reset &&
                      (phase == PH_CMD || phase == PH_ADDR || phase == PH_DATA);
   assign rd_take   = rd_req && !bus_reset && (phase == PH_WCRC || phase == PH_READ);

   assign wr_start  = rx_take && phase == PH_CMD && byte_done && full_byte == CMD_WR;
   assign copy_evt  = rx_take && phase == PH_CMD && byte_done && full_byte == CMD_CP;
   assign data_evt  = rx_take && phase == PH_DATA;

   assign ta_lo_we  = rx_take && phase == PH_ADDR && cnt == CNT_W'(7);
   assign ta_hi_we  = rx_take && phase == PH_ADDR && cnt == CNT_W'(15);
   assign ta_din    = ta_lo_we ? {full_byte[7:OFS_W], {OFS_W{1'b0}}} : full_byte;
   assign d_we      = data_evt && byte_done;

   assign crc_en    = rx_take || (rd_take && phase == PH_READ && cnt < CNT_W'(PAY_BITS));
   assign crc_din   = rx_take ? rx_bit : tx_bit;

   assign es = {aa, 1'b1, pf, 5'b11111};

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CMD;
         cnt   <= '0;
         sh    <= '0;
      end else if (bus_reset) begin
         phase <= PH_CMD;
         cnt   <= '0;
      end else if (rx_take) begin
         sh <= full_byte;
         unique case (phase)
            PH_CMD: begin
               if (byte_done) begin
                  cnt <= '0;
                  if (full_byte == CMD_WR)      phase <= PH_ADDR;
                  else if (full_byte == CMD_RD) phase <= PH_READ;
                  else                          phase <= PH_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_ADDR: begin
               if (cnt == CNT_W'(15)) begin
                  cnt   <= '0;
                  phase <= PH_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == CNT_W'(DATA_BITS - 1)) begin
                  cnt   <= '0;
                  phase <= PH_WCRC;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end else if (rd_take) begin
         if (phase == PH_WCRC && cnt == CNT_W'(15)) begin
            cnt   <= '0;
            phase <= PH_IDLE;
         end else if (phase == PH_READ && cnt == CNT_W'(RD_BITS - 1)) begin
            cnt   <= '0;
            phase <= PH_IDLE;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // Outgoing bit selection
   always_comb begin
      rd_bi   = 32'(cnt[CNT_W-1:3]);
      rd_byte = 8'hFF;
      if (rd_bi == 0)                rd_byte = ta_lo;
      else if (rd_bi == 1)           rd_byte = ta_hi;
      else if (rd_bi == 2)           rd_byte = es;
      else if (rd_bi < BYTES + 3)    rd_byte = data_flat[(rd_bi - 3) * 8 +: 8];
      else if (rd_bi == BYTES + 3)   rd_byte = crc_inv[7:0];
      else                           rd_byte = crc_inv[15:8];
   end

   always_comb begin
      unique case (phase)
         PH_WCRC: tx_bit = crc_inv[cnt[3:0]];
         PH_READ: tx_bit = rd_byte[cnt[2:0]];
         default: tx_bit = 1'b1;
      endcase
   end

   spad_crc16 #(.POLY_REFL(CRC_POLY), .INVERT_OUT(1'b1)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (bus_reset),
      .en      (crc_en),
      .din     (crc_din),
      .crc_out (crc_inv)
   );

   spad_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_start     (wr_start),
      .data_evt     (data_evt),
      .data_aligned (byte_done),
      .copy_evt     (copy_evt),
      .auth_ok      (auth_ok),
      .pf           (pf),
      .aa           (aa)
   );

   spad_store #(.BYTES(BYTES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ta_lo_we  (ta_lo_we),
      .ta_hi_we  (ta_hi_we),
      .ta_din    (ta_din),
      .d_we      (d_we),
      .d_idx     (cnt[OFS_W+2:3]),
      .d_din     (full_byte),
      .ta_lo     (ta_lo),
      .ta_hi     (ta_hi),
      .data_flat (data_flat)
   );

   assert_abort_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (phase == PH_CMD && cnt == '0));

   assert_data_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_DATA |-> cnt < CNT_W'(DATA_BITS));

   assert_crc_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && phase == PH_WCRC && cnt == CNT_W'(15)) |=> (phase == PH_IDLE && tx_bit));

endmodule

// File: tb/spad_wr_ctrl_test.sv
module spad_wr_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0;
   logic rx_valid = 1'b0;
   logic rx_bit = 1'b0;
   logic rd_req = 1'b0;
   logic auth_ok = 1'b0;
   logic tx_bit;

   int n_checks = 0;
   int n_err = 0;
   int cycles = 0;

   logic [7:0] m_data [8];
   logic [7:0] m_ta1, m_ta2;
   logic       m_pf, m_aa;

   always #4 clk = ~clk;

   spad_wr_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_reset (bus_reset),
      .rx_valid  (rx_valid),
      .rx_bit    (rx_bit),
      .rd_req    (rd_req),
      .auth_ok   (auth_ok),
      .tx_bit    (tx_bit)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         n_err++;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

   function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
      logic [15:0] n;
      n = c >> 1;
      if (c[0] ^ b) n = n ^ 16'hA001;
      return n;
   endfunction

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] v);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) r = crc_bit(r, v[i]);
      return r;
   endfunction

   function automatic logic [7:0] es_model();
      return {m_aa, 1'b1, m_pf, 5'b11111};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic read_byte(output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); v[i] = tx_bit; rd_req = 1'b1;
         @(negedge clk); rd_req = 1'b0;
      end
   endtask

   // R8 readback frame against the model
   task automatic rd_spad(input string req);
      logic [7:0] exp [13];
      logic [7:0] got;
      logic [15:0] c;
      pulse_reset();
      send_byte(8'hAA);
      exp[0] = m_ta1; exp[1] = m_ta2; exp[2] = es_model();
      for (int k = 0; k < 8; k++) exp[3+k] = m_data[k];
      c = crc_byte(16'h0, 8'hAA);
      for (int k = 0; k < 11; k++) c = crc_byte(c, exp[k]);
      c = ~c;
      exp[11] = c[7:0]; exp[12] = c[15:8];
      for (int k = 0; k < 13; k++) begin
         read_byte(got);
         chk($sformatf("%s R8 byte%0d", req, k), {8'h0, got}, {8'h0, exp[k]});
      end
   endtask

   // R2 R3 R5 R6 R7: write with nbits data bits
   task automatic do_write(input logic [7:0] lo, input logic [7:0] hi,
                           input logic [63:0] d, input int nbits, input int extra);
      logic [15:0] c;
      logic [7:0]  got;
      pulse_reset();
      send_byte(8'h0F);
      m_aa = 1'b0;
      send_byte(lo);
      m_ta1 = lo & 8'hF8;
      send_byte(hi);
      m_ta2 = hi;
      for (int i = 0; i < nbits && i < 64; i++) send_bit(d[i]);
      for (int k = 0; k < 8; k++) if ((k + 1) * 8 <= nbits) m_data[k] = d[k*8 +: 8];
      if (nbits > 0) m_pf = (nbits >= 64) ? 1'b0 : (nbits % 8 != 0);
      if (nbits >= 64) begin
         for (int i = 0; i < extra; i++) send_bit(~d[i]);  // R3 ignored bits
         c = crc_byte(16'h0, 8'h0F);
         c = crc_byte(c, lo);
         c = crc_byte(c, hi);
         for (int k = 0; k < 8; k++) c = crc_byte(c, d[k*8 +: 8]);
         c = ~c;
         read_byte(got);
         chk("R7 write crc low", {8'h0, got}, {8'h0, c[7:0]});
         read_byte(got);
         chk("R7 write crc high", {8'h0, got}, {8'h0, c[15:8]});
         read_byte(got);
         chk("R11 slot after crc", {8'h0, got}, 16'h00FF);
      end
   endtask

   task automatic do_copy(input logic a);
      pulse_reset();
      @(negedge clk); auth_ok = a;
      send_byte(8'h55);
      m_aa = a & ~m_pf;
      @(negedge clk); auth_ok = 1'b0;
   endtask

   initial begin
      logic [7:0]  got;
      logic [63:0] d;
      int          op, nb;
      void'($urandom(32'd20240611));
      for (int k = 0; k < 8; k++) m_data[k] = 8'h00;
      m_ta1 = 8'h00; m_ta2 = 8'h00; m_pf = 1'b1; m_aa = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 tx idle in reset", {15'h0, tx_bit}, 16'h1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10 R4 power-on state: status 0x7F
      rd_spad("R10 R4 power-on");
      chk("R4 status encoding after reset", {8'h0, es_model()}, 16'h007F);

      // R2 forced low bits, R3 R7 full write with extra bits
      do_write(8'h5D, 8'hC3, 64'h0123_4567_89AB_CDEF, 64, 5);
      rd_spad("R2 R3 R5 full write");

      // R6 copy with and without authorization
      do_copy(1'b1);
      rd_spad("R6 copy accepted");
      chk("R6 aa set", {15'h0, m_aa}, 16'h1);
      do_copy(1'b0);
      rd_spad("R6 copy refused");

      // R5 partial byte, R3 partial byte dropped, R6 copy blocked by partial
      do_write(8'hFF, 8'h12, 64'hFEDC_BA98_7654_3210, 29, 0);
      rd_spad("R5 partial write");
      do_copy(1'b1);
      rd_spad("R6 copy blocked by partial");

      // R9 abort after low address byte only
      pulse_reset();
      send_byte(8'h0F);
      m_aa = 1'b0;
      send_byte(8'h97);
      m_ta1 = 8'h90;
      rd_spad("R9 abort in address");

      // R9 abort in mid readback, then full readback
      pulse_reset();
      send_byte(8'hAA);
      read_byte(got);
      read_byte(got);
      rd_spad("R9 abort in readback");

      // R1 R11 unknown command: idle slots and ignored bits
      pulse_reset();
      send_byte(8'h33);
      read_byte(got);
      chk("R11 R1 idle slot after unknown cmd", {8'h0, got}, 16'h00FF);
      send_byte(8'h0F);
      send_byte(8'h00);
      rd_spad("R1 unknown command ignored");

      // R1 R11 read slots during a write before data end
      pulse_reset();
      send_byte(8'h0F);
      m_aa = 1'b0;
      read_byte(got);
      chk("R11 slot during address phase", {8'h0, got}, 16'h00FF);
      send_byte(8'h40);
      m_ta1 = 8'h40;
      send_byte(8'h41);
      m_ta2 = 8'h41;
      rd_spad("R11 state after idle slots");

      // Random mix
      for (int it = 0; it < 30; it++) begin
         op = $urandom % 4;
         d = {$urandom, $urandom};
         if (op == 0) begin
            do_write(8'($urandom), 8'($urandom), d, 64, $urandom % 4);
         end else if (op == 1) begin
            nb = $urandom % 64;
            do_write(8'($urandom), 8'($urandom), d, nb, 0);
         end else if (op == 2) begin
            do_copy(1'($urandom));
         end else begin
            rd_spad("R8 random readback");
         end
      end
      rd_spad("R8 final readback");

      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

endmodule